// File: doc/BRIEF.md
# Serial Command-Register Port

This block is the slave side of a four-wire serial link. Through it a host reaches a small bank of internal configuration registers. Every exchange has two phases. First the host shifts in one command byte while chip select is low. That byte names a target register and says whether the next phase reads it or writes it. Then the host moves exactly as many data bits as that register is wide: 8, 16 or 24. After the data phase the port waits for a fresh command byte, so several transactions can follow one another inside a single chip-select window.

The serial clock, chip select and data input are not used as clocks. They pass through synchronisers into the system clock domain, and serial clock edges are found by comparing successive samples. Input bits are taken on rising serial clock edges, most significant bit first. Read data changes on falling edges.

The port also watches for a recovery pattern. A run of 32 consecutive ones on the data input, while chip select is low, returns the port and every register to its default state. The port signals this with a one-cycle reset pulse.

Top module: `serCmdPort`

## Requirements
- R1: The command byte is shifted MSB first on rising serial clock edges. Bit 6 = 1 requests a read and bit 6 = 0 a write; bits 5..0 are the register address. Read data leaves MSB first and changes only on falling serial clock edges.
- R2: Address map and widths:
  - Address 0x01 is an 8-bit setup register with reset value 0x21.
  - Addresses 0x08–0x0F are 8-bit per-channel registers.
  - Addresses 0x10–0x17 are 16-bit per-channel registers.
  - Addresses 0x18–0x1F are 24-bit per-channel registers.
  - Within a bank, address bits 2..0 give the channel. All per-channel registers reset to zero.
- R3: The data phase lasts exactly the width of the addressed register. Once it ends, the next 8 bits form a new command byte, even when chip select stays low.
- R4: Every other address is unmapped. Its data phase is 8 bits long, it reads back as zero, and a write to it changes no register.
- R5: 32 consecutive ones on the data input, sampled on rising serial clock edges with chip select low, reset every register to its default. They also drive the reset output high for exactly one system clock cycle, and the port then expects a command byte.
- R6: A run of fewer than 32 ones, or a run split by chip select going high, resets nothing.
- R7: Chip select going high in the middle of a transaction cancels it without writing, and the next command is handled normally.
- R8: The data output is low whenever chip select has been high for a few system clocks, and after reset.
- R9: A command byte with bit 7 set starts no data phase. The 8 bits that follow it are taken as a new command byte.
- R10: Each of the eight channel addresses in a bank holds its own independent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host, idle low |
| csNIn | input | 1 | Active-low chip select |
| dinIn | input | 1 | Serial data from the host |
| doutOut | output | 1 | Serial read data to the host |
| resyncOut | output | 1 | One-cycle pulse when the ones-run recovery fires |

## Verification
The assertions assume the following about the inputs:
- Chip select and data input are stable for several system clocks around each serial clock edge, so that their synchronised copies line up with the detected edge.
- The serial clock is slow enough that each half period spans more than the synchroniser depth.

The stimulus keeps to these limits. It changes the data input only while the serial clock is low, holds each serial clock level for six system clocks, and leaves chip select quiet for several clocks on either side of each window. During read phases it holds the data input low, so that the ones run cannot reach 32 by accident.

// File: rtl/serCmdPkg.sv
package serCmdPkg;
  localparam int CMD_W   = 8;
  localparam int ADDR_W  = 6;
  localparam int CH_BITS = 3;
  localparam int NUM_CH  = 1 << CH_BITS;
  localparam int DATA_W  = 24;
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int BANK_W  = ADDR_W - CH_BITS;

  localparam logic [ADDR_W-1:0] SETUP_ADDR    = ADDR_W'(1);
  localparam logic [DATA_W-1:0] SETUP_DEFAULT = DATA_W'(24'h21);
  localparam logic [BANK_W-1:0] BANK_NARROW   = BANK_W'(1);
  localparam logic [BANK_W-1:0] BANK_MID      = BANK_W'(2);
  localparam logic [BANK_W-1:0] BANK_WIDE     = BANK_W'(3);

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_t;

  typedef struct packed {
    logic shiftIn;
    logic loadCmd;
    logic loadRead;
    logic commitWrite;
    logic shiftOut;
    logic clearOut;
    logic resync;
  } strobe_t;

  function automatic logic [CNT_W-1:0] widthOf(input logic [ADDR_W-1:0] a);
    case (a[ADDR_W-1:CH_BITS])
      BANK_MID:  return CNT_W'(16);
      BANK_WIDE: return CNT_W'(24);
      default:   return CNT_W'(8);
    endcase
  endfunction

  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    return (a == SETUP_ADDR) || (a[ADDR_W-1:CH_BITS] == BANK_NARROW) ||
           (a[ADDR_W-1:CH_BITS] == BANK_MID) || (a[ADDR_W-1:CH_BITS] == BANK_WIDE);
  endfunction

  function automatic logic [DATA_W-1:0] defaultOf(input logic [ADDR_W-1:0] a);
    return (a == SETUP_ADDR) ? SETUP_DEFAULT : '0;
  endfunction
endpackage

// File: rtl/serCmdSync.sv
module serCmdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dinIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csLow,
  output logic dinS
);
  logic [STAGES-1:0] sclkPipe, csPipe, dinPipe;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      dinPipe  <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      dinPipe  <= {dinPipe[STAGES-2:0], dinIn};
      sclkLast <= sclkPipe[STAGES-1];
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;
  assign csLow    = ~csPipe[STAGES-1];
  assign dinS     = dinPipe[STAGES-1];
endmodule

// File: rtl/serCmdCtrl.sv
module serCmdCtrl
  import serCmdPkg::*;
#(
  parameter int RESYNC_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkRise,
  input  logic             sclkFall,
  input  logic             csLow,
  input  logic             dinS,
  input  logic [1:0]       cmdTop,
  input  logic [CNT_W-1:0] dataWidth,
  output strobe_t          strb,
  output phase_t           phase
);
  localparam int ONES_W = $clog2(RESYNC_LEN + 1);

  logic [ONES_W-1:0] onesCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic edgeIn, resyncHit, cmdDone, dataDone;

  assign edgeIn    = sclkRise & csLow;
  assign resyncHit = edgeIn & dinS & (onesCnt == ONES_W'(RESYNC_LEN - 1));
  assign cmdDone   = (phase == PH_CMD) && (bitCnt == CNT_W'(CMD_W - 1));
  assign dataDone  = (phase != PH_CMD) && (bitCnt == dataWidth - CNT_W'(1));

  always_comb begin
    strb             = '0;
    strb.resync      = resyncHit;
    strb.shiftIn     = edgeIn & ~resyncHit;
    strb.loadCmd     = strb.shiftIn & cmdDone & ~cmdTop[1];
    strb.loadRead    = strb.loadCmd & cmdTop[0];
    strb.commitWrite = strb.shiftIn & (phase == PH_WR) & dataDone;
    strb.shiftOut    = sclkFall & csLow & (phase == PH_RD);
    strb.clearOut    = ~csLow | (sclkFall & (phase != PH_RD));
  end

  // ones-run counter for the recovery pattern
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               onesCnt <= '0;
    else if (!csLow)         onesCnt <= '0;
    else if (edgeIn) begin
      if (resyncHit)         onesCnt <= '0;
      else if (dinS)         onesCnt <= onesCnt + ONES_W'(1);
      else                   onesCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
    end else if (!csLow || resyncHit) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
    end else if (strb.shiftIn) begin
      if (phase == PH_CMD) begin
        if (cmdDone) begin
          bitCnt <= '0;
          if (cmdTop[1])      phase <= PH_CMD;
          else if (cmdTop[0]) phase <= PH_RD;
          else                phase <= PH_WR;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end else if (dataDone) begin
        bitCnt <= '0;
        phase  <= PH_CMD;
      end else begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/serCmdDatapath.sv
module serCmdDatapath
  import serCmdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dinS,
  input  strobe_t          strb,
  output logic [1:0]       cmdTop,
  output logic [CNT_W-1:0] dataWidth,
  output logic             doutOut,
  output logic             resyncOut
);
  localparam int SPAN   = 4 * NUM_CH;
  localparam int SPAN_W = $clog2(SPAN);

  logic [DATA_W-2:0]   shReg;
  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   rdShift;
  logic [CMD_W-1:0]    cmdNext;
  logic [DATA_W-1:0]   wrWord;
  logic [ADDR_W-1:0]   selAddr;
  logic [DATA_W-1:0]   readVal;
  logic [DATA_W-1:0]   readAligned;
  logic [DATA_W-1:0]   regView [SPAN];

  assign cmdNext   = {shReg[CMD_W-2:0], dinS};
  assign wrWord    = {shReg, dinS};
  assign cmdTop    = cmdNext[CMD_W-1:CMD_W-2];
  assign selAddr   = cmdNext[ADDR_W-1:0];
  assign dataWidth = widthOf(addrQ);

  // one storage slot per mapped address, sized to its width
  for (genvar a = 0; a < SPAN; a++) begin : g_slot
    localparam logic [ADDR_W-1:0] A = ADDR_W'(a);
    localparam int W = int'(widthOf(A));
    if (isMapped(A)) begin : g_live
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                q <= W'(defaultOf(A));
        else if (strb.resync)                     q <= W'(defaultOf(A));
        else if (strb.commitWrite && addrQ == A)  q <= wrWord[W-1:0];
      end
      assign regView[a] = DATA_W'(q);
    end else begin : g_none
      assign regView[a] = '0;
    end
  end

  always_comb begin
    if (selAddr[ADDR_W-1:SPAN_W] == '0) readVal = regView[selAddr[SPAN_W-1:0]];
    else                                readVal = '0;
    readAligned = readVal << (DATA_W - int'(widthOf(selAddr)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      addrQ     <= '0;
      rdShift   <= '0;
      doutOut   <= 1'b0;
      resyncOut <= 1'b0;
    end else begin
      resyncOut <= strb.resync;
      if (strb.resync) begin
        shReg   <= '0;
        addrQ   <= '0;
        rdShift <= '0;
        doutOut <= 1'b0;
      end else begin
        if (strb.shiftIn)  shReg <= {shReg[DATA_W-3:0], dinS};
        if (strb.loadCmd)  addrQ <= selAddr;
        if (strb.loadRead) rdShift <= readAligned;
        else if (strb.shiftOut) rdShift <= {rdShift[DATA_W-2:0], 1'b0};
        if (strb.clearOut)      doutOut <= 1'b0;
        else if (strb.shiftOut) doutOut <= rdShift[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/serCmdPort.sv
module serCmdPort
  import serCmdPkg::*;
#(
  parameter int RESYNC_LEN  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dinIn,
  output logic doutOut,
  output logic resyncOut
);
  logic sclkRise, sclkFall, csLow, dinS;
  logic [1:0] cmdTop;
  logic [CNT_W-1:0] dataWidth;
  strobe_t strb;
  phase_t  phase;

  serCmdSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dinIn(dinIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csLow(csLow), .dinS(dinS)
  );

  serCmdCtrl #(.RESYNC_LEN(RESYNC_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csLow(csLow), .dinS(dinS), .cmdTop(cmdTop), .dataWidth(dataWidth),
    .strb(strb), .phase(phase)
  );

  serCmdDatapath u_dp (
    .clk(clk), .rstN(rstN), .dinS(dinS), .strb(strb), .cmdTop(cmdTop),
    .dataWidth(dataWidth), .doutOut(doutOut), .resyncOut(resyncOut)
  );
endmodule

// File: rtl/serCmdPort_chk.sv
module serCmdPort_chk
  import serCmdPkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   csNIn,
  input logic   doutOut,
  input logic   resyncOut,
  input logic   resyncStrb,
  input logic   commitStrb,
  input phase_t phase
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R5: recovery strobe shows on the reset output one cycle later
  p_resync_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resyncStrb |=> resyncOut);

  // R5: reset output never lasts more than one cycle
  p_resync_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    resyncOut |=> !resyncOut);

  // R5: after recovery the port waits for a command byte
  p_resync_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    resyncOut |-> phase == PH_CMD);

  // R3: a completed write returns to the command phase
  p_commit_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitStrb |=> phase == PH_CMD);

  // R7: chip select held high forces the command phase
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3))
      |-> phase == PH_CMD);

  // R8: data output low while chip select stays high
  p_idle_dout_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3))
      |-> !doutOut);
endmodule

bind serCmdPort serCmdPort_chk u_chk (
  .clk(clk), .rstN(rstN), .csNIn(csNIn), .doutOut(doutOut),
  .resyncOut(resyncOut), .resyncStrb(strb.resync),
  .commitStrb(strb.commitWrite), .phase(phase)
);

// File: tb/serCmdPort_tb.sv
module serCmdPort_tb;
  localparam int HALF = 6;
  localparam int NVEC = 17;
  // {read, address, write data}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 6'h08, 24'h0000A5}, {1'b0, 6'h0F, 24'h00003C},
    {1'b0, 6'h10, 24'h00BEEF}, {1'b0, 6'h17, 24'h001234},
    {1'b0, 6'h18, 24'hC0FFEE}, {1'b0, 6'h1F, 24'h00F00D},
    {1'b0, 6'h01, 24'h000077}, {1'b0, 6'h25, 24'h000099},
    {1'b1, 6'h08, 24'h0}, {1'b1, 6'h0F, 24'h0}, {1'b1, 6'h10, 24'h0},
    {1'b1, 6'h17, 24'h0}, {1'b1, 6'h18, 24'h0}, {1'b1, 6'h1F, 24'h0},
    {1'b1, 6'h01, 24'h0}, {1'b1, 6'h25, 24'h0}, {1'b1, 6'h09, 24'h0}
  };

  logic clk = 0, rstN = 0, sclk = 0, csN = 1, din = 0;
  logic dout, resyncOut;
  int total = 0, bad = 0, pulseCycles = 0;
  logic [23:0] model [64];

  always #2 clk = ~clk;

  serCmdPort u_dut (.clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN),
                    .dinIn(din), .doutOut(dout), .resyncOut(resyncOut));

  always @(negedge clk) if (resyncOut) pulseCycles++;

  function automatic int bWidth(input logic [5:0] a);
    if (a[5:3] == 3'd2) return 16;
    if (a[5:3] == 3'd3) return 24;
    return 8;
  endfunction
  function automatic bit bMapped(input logic [5:0] a);
    return a == 6'h01 || a[5:3] == 3'd1 || a[5:3] == 3'd2 || a[5:3] == 3'd3;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) model[i] = (i == 1) ? 24'h21 : 24'h0;
  endtask

  task automatic checkEq(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitCycle(input logic d, output logic q);
    din = d;
    waitClk(HALF);
    q = dout;
    sclk = 1;
    waitClk(HALF);
    sclk = 0;
  endtask

  task automatic shiftBits(input logic [23:0] v, input int n, output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitCycle(v[i], b);
      r = {r[22:0], b};
    end
    din = 0;
  endtask

  task automatic csLowT(); csN = 0; waitClk(8); endtask
  task automatic csHighT(); waitClk(4); csN = 1; waitClk(12); endtask

  task automatic doWrite(input logic [5:0] a, input logic [23:0] d);
    logic [23:0] r;
    csLowT();
    shiftBits({16'h0, 2'b00, a}, 8, r);
    shiftBits(d, bWidth(a), r);
    csHighT();
    if (bMapped(a)) model[a] = d & ((24'h1 << bWidth(a)) - 24'h1);
  endtask

  task automatic doRead(input logic [5:0] a, output logic [23:0] r);
    logic [23:0] s;
    csLowT();
    shiftBits({16'h0, 2'b01, a}, 8, s);
    shiftBits(24'h0, bWidth(a), r);
    csHighT();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] r, s;
    int p0;
    modelReset();
    waitClk(5);
    rstN = 1;
    waitClk(5);

    // reset state
    checkEq("R8 dout after reset", {23'h0, dout}, 24'h0);
    checkEq("R5 no pulse after reset", {23'h0, resyncOut}, 24'h0);
    doRead(6'h01, r); checkEq("R2 setup default", r, 24'h21);
    doRead(6'h1A, r); checkEq("R2 wide default", r, 24'h0);

    // vector table: writes then reads (R1, R2, R4, R10)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][30]) begin
        doRead(VEC[i][29:24], r);
        checkEq($sformatf("R1/R2/R4/R10 vec%0d addr %h", i, VEC[i][29:24]), r, model[VEC[i][29:24]]);
      end else begin
        doWrite(VEC[i][29:24], VEC[i][23:0]);
      end
    end

    // R8: data output low with chip select high after a read ending in 1
    doRead(6'h1F, r);
    checkEq("R8 dout idle", {23'h0, dout}, 24'h0);

    // R3: write then read within one chip-select window
    csLowT();
    shiftBits(24'h11, 8, s); shiftBits(24'h0102, 16, s);
    shiftBits(24'h51, 8, s); shiftBits(24'h0, 16, r);
    csHighT();
    model[6'h11] = 24'h0102;
    checkEq("R3 back to back", r, 24'h0102);

    // R9: invalid command, following byte is a command
    csLowT();
    shiftBits(24'h88, 8, s); shiftBits(24'h0A, 8, s); shiftBits(24'h5A, 8, s);
    csHighT();
    model[6'h0A] = 24'h5A;
    doRead(6'h0A, r); checkEq("R9 next byte is command", r, 24'h5A);
    doRead(6'h08, r); checkEq("R9 invalid byte wrote nothing", r, 24'hA5);

    // R7: abort a write part way through
    csLowT();
    shiftBits(24'h10, 8, s); shiftBits(24'h2AA, 10, s);
    csHighT();
    doRead(6'h10, r); checkEq("R7 aborted write", r, 24'hBEEF);
    // R7: abort a read, then a normal write
    csLowT();
    shiftBits(24'h58, 8, s); shiftBits(24'h0, 5, s);
    csHighT();
    doWrite(6'h0B, 24'h11);
    doRead(6'h0B, r); checkEq("R7 command after abort", r, 24'h11);

    // R6: two runs of 31 ones, split by chip select
    p0 = pulseCycles;
    doWrite(6'h09, 24'h42);
    csLowT(); shiftBits(24'hFFFFFF, 24, s); shiftBits(24'h7F, 7, s); csHighT();
    csLowT(); shiftBits(24'hFFFFFF, 24, s); shiftBits(24'h7F, 7, s); csHighT();
    checkEq("R6 no pulse", pulseCycles - p0, 24'h0);
    doRead(6'h09, r); checkEq("R6 register kept", r, 24'h42);

    // R5: 32 ones, then a read in the same window
    p0 = pulseCycles;
    csLowT();
    shiftBits(24'hFFFFFF, 24, s); shiftBits(24'hFF, 8, s);
    shiftBits(24'h49, 8, s); shiftBits(24'h0, 8, r);
    csHighT();
    modelReset();
    checkEq("R5 one-cycle pulse", pulseCycles - p0, 24'h1);
    checkEq("R5 channel reg cleared", r, 24'h0);
    doRead(6'h01, r); checkEq("R5 setup restored", r, 24'h21);
    doRead(6'h18, r); checkEq("R5 wide reg cleared", r, 24'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule